// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for each incoming Ethernet frame, whether the receiver should keep it. The destination address arrives as a stream of six bytes, first byte first. The frame length is presented alongside the sixth byte. One cycle later the block gives a single-cycle result: accept or reject, plus a flag that marks an accepted broadcast.

The decision works through a fixed order of tests:
- a receiver gate (suspended, or link down);
- a minimum-length test;
- promiscuous acceptance;
- broadcast handling with an optional disable;
- multicast matching through a 64-entry hash table;
- an exact match against the station's own individual address.

The hash table is filled through a separate load port. A load begins with a start pulse and a list byte count. The block then takes the list of addresses and sets one table bit for each complete six-byte entry.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset `res_valid`, `res_accept` and `res_bcast` are 0 and every hash table bit is clear, so a multicast frame is rejected until a list has been loaded.
- R2: While `rx_suspended` is 1 or `link_up` is 0 at the sixth address byte, the frame is rejected; this test takes priority over every other test.
- R3: The effective minimum length is the larger of `cfg_min_len` and 5. A frame whose `frame_len` is below it is rejected. This test takes priority over the address tests.
- R4: With `cfg_promisc` set, every frame that passes R2 and R3 is accepted, and `res_bcast` stays 0.
- R5: A destination of all ones is broadcast. It is rejected when `cfg_bcast_off` is 1. Otherwise it is accepted with `res_bcast` set to 1. `res_bcast` is 1 only together with an accept.
- R6: A destination whose first byte has bit 0 set (and that is not broadcast) is multicast. It is rejected when `cfg_mcast_en` is 0.
- R7: With `cfg_mcast_en` set, a multicast frame is accepted only if its table bit is set. The CRC is a reflected CRC-32: polynomial 0xEDB88320, initial value all ones, no final inversion, each byte taken LSB first, address byte 0 first. The 6-bit index is CRC bits 7:2 after the sixth byte. Index bits 5:3 pick the table byte and bits 2:0 the bit within it, which makes the table bit number equal to the index.
- R8: An `ld_start` pulse clears the whole table. `ld_valid` in the same cycle is ignored.
- R9: A load registers floor(`ld_len`/6) entries, capped at `MC_MAX` (default 8). Bytes past `ld_len`, entries past the cap and a trailing partial entry set no bit.
- R10: A frame that is neither broadcast nor multicast is accepted only when all six bytes equal `ia_addr`, byte 0 in bits 7:0. Any other such frame is rejected.
- R11: `res_valid` is a one-cycle pulse in the cycle after the clock edge that takes the sixth address byte. `res_accept` and `res_bcast` are 0 whenever `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_bcast_off | input | 1 | Reject broadcast frames |
| cfg_mcast_en | input | 1 | Allow multicast frames through the hash table |
| cfg_min_len | input | 8 | Configured minimum frame length (floored at 5) |
| rx_suspended | input | 1 | Receiver suspended: reject all |
| link_up | input | 1 | Link state: 0 rejects all |
| ia_addr | input | 48 | Individual address, byte 0 in bits 7:0 |
| addr_valid | input | 1 | Destination byte strobe |
| addr_byte | input | 8 | Destination byte, first byte first |
| frame_len | input | 16 | Frame length, sampled with the sixth byte |
| ld_start | input | 1 | Begin table load: clear table, take byte count |
| ld_len | input | 16 | List length in bytes |
| ld_valid | input | 1 | List byte strobe |
| ld_byte | input | 8 | List byte |
| res_valid | output | 1 | Decision pulse |
| res_accept | output | 1 | Frame accepted |
| res_bcast | output | 1 | Accepted frame is broadcast |

## Verification
The decision is tried with broadcast, own-address, near-miss own-address (one differing byte), multicast addresses taken from the loaded list, multicast addresses whose table bit is known clear, and fully random addresses. Each of these is run under random mixes of the configuration flags, the gate inputs and lengths around the floor. Directed loads with more entries than the cap, a trailing partial entry and a reload show whether the table is cleared and whether the cap and byte count are honoured. Lengths 4 and 5 with a zero minimum, and 19 and 20 with a minimum of 20, separate the floor from the configured value.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

  // one byte of reflected CRC-32, LSB of the byte first
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r >> 1) ^ (CRC_POLY & {32{r[0] ^ d[i]}});
    return r;
  endfunction
endpackage

// File: rtl/rxf_addr_capture.sv
module rxf_addr_capture #(
  parameter int NBYTES = 6,
  parameter int HASH_W = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [7:0]            in_byte,
  output logic                  out_last,
  output logic [8*NBYTES-1:0]   out_addr,
  output logic [HASH_W-1:0]     out_hash
);
  import rxf_pkg::*;
  localparam int CNT_W  = $clog2(NBYTES);
  localparam int HELD_W = 8 * (NBYTES - 1);

  logic [CNT_W-1:0]  cnt;
  logic [31:0]       crc, crc_nx;
  logic [HELD_W-1:0] held;

  always_comb begin
    crc_nx   = crc_step(crc, in_byte);
    out_last = in_valid && (cnt == CNT_W'(NBYTES - 1));
    out_addr = {in_byte, held};
    out_hash = crc_nx[HASH_W+1:2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      crc  <= CRC_INIT;
      held <= '0;
    end else if (in_valid) begin
      if (out_last) begin
        cnt <= '0;
        crc <= CRC_INIT;
      end else begin
        cnt  <= cnt + 1'b1;
        crc  <= crc_nx;
        held <= {in_byte, held[HELD_W-1:8]};
      end
    end
  end
endmodule

// File: rtl/rxf_hash_table.sv
module rxf_hash_table #(
  parameter int NBYTES = 6,
  parameter int HASH_W = 6,
  parameter int MC_MAX = 8,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_start,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic              ld_valid,
  input  logic [7:0]        ld_byte,
  input  logic [HASH_W-1:0] look_idx,
  output logic              look_hit
);
  import rxf_pkg::*;
  localparam int TBL   = 1 << HASH_W;
  localparam int POS_W = $clog2(NBYTES);
  localparam int ENT_W = $clog2(MC_MAX + 1);

  logic [TBL-1:0]   tbl;
  logic [LEN_W-1:0] rem;
  logic [POS_W-1:0] pos;
  logic [ENT_W-1:0] ent;
  logic [31:0]      crc, crc_nx;
  logic [HASH_W-1:0] set_idx;

  always_comb begin
    crc_nx   = crc_step(crc, ld_byte);
    set_idx  = crc_nx[HASH_W+1:2];
    look_hit = tbl[look_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl <= '0;
      rem <= '0;
      pos <= '0;
      ent <= '0;
      crc <= CRC_INIT;
    end else if (ld_start) begin
      tbl <= '0;
      rem <= ld_len;
      pos <= '0;
      ent <= '0;
      crc <= CRC_INIT;
    end else if (ld_valid && rem != '0) begin
      rem <= rem - 1'b1;
      if (pos == POS_W'(NBYTES - 1)) begin
        pos <= '0;
        crc <= CRC_INIT;
        if (ent < ENT_W'(MC_MAX)) begin
          tbl[set_idx] <= 1'b1;
          ent          <= ent + 1'b1;
        end
      end else begin
        pos <= pos + 1'b1;
        crc <= crc_nx;
      end
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int NBYTES    = 6,
  parameter int HASH_W    = 6,
  parameter int MC_MAX    = 8,
  parameter int LEN_W     = 16,
  parameter int MINLEN_W  = 8,
  parameter int MIN_FLOOR = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_promisc,
  input  logic                 cfg_bcast_off,
  input  logic                 cfg_mcast_en,
  input  logic [MINLEN_W-1:0]  cfg_min_len,
  input  logic                 rx_suspended,
  input  logic                 link_up,
  input  logic [8*NBYTES-1:0]  ia_addr,
  input  logic                 addr_valid,
  input  logic [7:0]           addr_byte,
  input  logic [LEN_W-1:0]     frame_len,
  input  logic                 ld_start,
  input  logic [LEN_W-1:0]     ld_len,
  input  logic                 ld_valid,
  input  logic [7:0]           ld_byte,
  output logic                 res_valid,
  output logic                 res_accept,
  output logic                 res_bcast
);
  localparam int AW = 8 * NBYTES;

  logic              cap_last;
  logic [AW-1:0]     cap_addr;
  logic [HASH_W-1:0] cap_hash;
  logic              hash_hit;
  logic [MINLEN_W-1:0] eff_min;
  logic              acc, bc;

  rxf_addr_capture #(.NBYTES(NBYTES), .HASH_W(HASH_W)) u_cap (
    .clk(clk), .rst(rst), .in_valid(addr_valid), .in_byte(addr_byte),
    .out_last(cap_last), .out_addr(cap_addr), .out_hash(cap_hash)
  );

  rxf_hash_table #(.NBYTES(NBYTES), .HASH_W(HASH_W), .MC_MAX(MC_MAX), .LEN_W(LEN_W)) u_tbl (
    .clk(clk), .rst(rst), .ld_start(ld_start), .ld_len(ld_len),
    .ld_valid(ld_valid), .ld_byte(ld_byte),
    .look_idx(cap_hash), .look_hit(hash_hit)
  );

  always_comb begin
    eff_min = (cfg_min_len < MINLEN_W'(MIN_FLOOR)) ? MINLEN_W'(MIN_FLOOR) : cfg_min_len;
    acc = 1'b0;
    bc  = 1'b0;
    if (rx_suspended || !link_up) begin
      acc = 1'b0;
    end else if (frame_len < LEN_W'(eff_min)) begin
      acc = 1'b0;
    end else if (cfg_promisc) begin
      acc = 1'b1;
    end else if (&cap_addr) begin
      acc = !cfg_bcast_off;
      bc  = !cfg_bcast_off;
    end else if (cap_addr[0]) begin
      acc = cfg_mcast_en && hash_hit;
    end else begin
      acc = (cap_addr == ia_addr);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_bcast  <= 1'b0;
    end else begin
      res_valid  <= cap_last;
      res_accept <= cap_last && acc;
      res_bcast  <= cap_last && bc;
    end
  end
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_promisc,
  input logic             cfg_bcast_off,
  input logic             rx_suspended,
  input logic             link_up,
  input logic             addr_valid,
  input logic [LEN_W-1:0] frame_len,
  input logic             res_valid,
  input logic             res_accept,
  input logic             res_bcast
);
  assert_gate_reject_R2: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && (rx_suspended || !link_up)) |=> !res_accept);

  assert_len_floor_R3: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && frame_len < LEN_W'(5)) |=> !res_accept);

  assert_bcast_off_R5: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && cfg_bcast_off && !cfg_promisc) |=> !res_bcast);

  assert_bcast_needs_accept_R5: assert property (@(posedge clk) disable iff (rst)
    res_bcast |-> res_accept);

  assert_promisc_no_bcast_R4: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && cfg_promisc) |=> !res_bcast);

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  assert_valid_follows_byte_R11: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(addr_valid));

  assert_quiet_outputs_R11: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!res_accept && !res_bcast));
endmodule

bind rx_addr_filter rx_addr_filter_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_promisc(cfg_promisc), .cfg_bcast_off(cfg_bcast_off),
  .rx_suspended(rx_suspended), .link_up(link_up), .addr_valid(addr_valid),
  .frame_len(frame_len), .res_valid(res_valid), .res_accept(res_accept),
  .res_bcast(res_bcast)
);

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
  localparam int MC_MAX = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_promisc = 0, cfg_bcast_off = 0, cfg_mcast_en = 0;
  logic [7:0] cfg_min_len = 0;
  logic rx_suspended = 0, link_up = 1;
  logic [47:0] ia_addr = 48'h0;
  logic addr_valid = 0;
  logic [7:0] addr_byte = 0;
  logic [15:0] frame_len = 64;
  logic ld_start = 0;
  logic [15:0] ld_len = 0;
  logic ld_valid = 0;
  logic [7:0] ld_byte = 0;
  logic res_valid, res_accept, res_bcast;

  int total = 0;
  int bad = 0;
  logic [63:0] mdl_tbl;
  logic [47:0] list [0:15];

  always #10 clk = ~clk;

  rx_addr_filter u_dut (
    .clk(clk), .rst(rst), .cfg_promisc(cfg_promisc), .cfg_bcast_off(cfg_bcast_off),
    .cfg_mcast_en(cfg_mcast_en), .cfg_min_len(cfg_min_len), .rx_suspended(rx_suspended),
    .link_up(link_up), .ia_addr(ia_addr), .addr_valid(addr_valid), .addr_byte(addr_byte),
    .frame_len(frame_len), .ld_start(ld_start), .ld_len(ld_len), .ld_valid(ld_valid),
    .ld_byte(ld_byte), .res_valid(res_valid), .res_accept(res_accept), .res_bcast(res_bcast)
  );

  function automatic logic [5:0] mdl_hash(input logic [47:0] a);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      if (c[0] != a[k]) c = {1'b0, c[31:1]} ^ 32'hEDB88320;
      else              c = {1'b0, c[31:1]};
    end
    return c[7:2];
  endfunction

  function automatic logic [1:0] mdl_decide(input logic [47:0] a, input logic [15:0] len);
    int mn;
    mn = (cfg_min_len < 5) ? 5 : int'(cfg_min_len);
    if (rx_suspended || !link_up) return 2'b00;
    if (int'(len) < mn) return 2'b00;
    if (cfg_promisc) return 2'b10;
    if (a == 48'hFFFF_FFFF_FFFF) return cfg_bcast_off ? 2'b00 : 2'b11;
    if (a[0]) return (cfg_mcast_en && mdl_tbl[mdl_hash(a)]) ? 2'b10 : 2'b00;
    return (a == ia_addr) ? 2'b10 : 2'b00;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic send(input logic [47:0] a, input logic [15:0] len, input string req);
    logic [1:0] e;
    e = mdl_decide(a, len);
    frame_len = len;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      addr_valid = 1'b1;
      addr_byte  = a[8*i +: 8];
    end
    @(negedge clk);
    addr_valid = 1'b0;
    check(req, {29'd0, res_valid, res_accept, res_bcast}, {29'd0, 1'b1, e});
    @(negedge clk);
    check("R11 pulse", {31'd0, res_valid}, 32'd0);
  endtask

  // load n list entries from list[], announcing byte count blen
  task automatic load(input int n, input int blen);
    int cnt;
    @(negedge clk);
    ld_start = 1'b1; ld_len = 16'(blen);
    ld_valid = 1'b1; ld_byte = 8'hA5;
    @(negedge clk);
    ld_start = 1'b0;
    for (int e = 0; e < n; e++)
      for (int b = 0; b < 6; b++) begin
        ld_valid = 1'b1; ld_byte = list[e][8*b +: 8];
        @(negedge clk);
      end
    ld_valid = 1'b0;
    mdl_tbl = '0;
    cnt = blen / 6;
    if (cnt > n) cnt = n;
    if (cnt > MC_MAX) cnt = MC_MAX;
    for (int e = 0; e < cnt; e++) mdl_tbl[mdl_hash(list[e])] = 1'b1;
  endtask

  function automatic logic [47:0] rnd_addr();
    return {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
  endfunction

  function automatic logic [47:0] miss_mcast();
    logic [47:0] a;
    for (int t = 0; t < 1000; t++) begin
      a = rnd_addr() | 48'h1;
      if (a != 48'hFFFF_FFFF_FFFF && !mdl_tbl[mdl_hash(a)]) return a;
    end
    return 48'h01;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [47:0] a;
    void'($urandom(32'd7321));
    mdl_tbl = '0;
    ia_addr = 48'h5634_1200_AB02;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset outputs", {29'd0, res_valid, res_accept, res_bcast}, 32'd0);

    // R1: empty table rejects multicast
    cfg_mcast_en = 1;
    send(48'h0000_0000_0001, 64, "R1 empty table");

    // R10 own address and near misses
    send(ia_addr, 64, "R10 exact match");
    send(ia_addr ^ 48'h8000_0000_0000, 64, "R10 last byte differs");
    send(ia_addr ^ 48'h0000_0000_0100, 64, "R10 second byte differs");

    // R5 broadcast
    send(48'hFFFF_FFFF_FFFF, 64, "R5 broadcast accepted");
    cfg_bcast_off = 1;
    send(48'hFFFF_FFFF_FFFF, 64, "R5 broadcast disabled");
    cfg_bcast_off = 0;

    // R3 length floor and configured minimum
    cfg_min_len = 0;
    send(ia_addr, 4, "R3 below floor");
    send(ia_addr, 5, "R3 at floor");
    cfg_min_len = 20;
    send(ia_addr, 19, "R3 below min");
    send(ia_addr, 20, "R3 at min");
    cfg_min_len = 0;

    // R2 gate
    rx_suspended = 1;
    send(ia_addr, 64, "R2 suspended");
    rx_suspended = 0; link_up = 0;
    send(48'hFFFF_FFFF_FFFF, 64, "R2 link down");
    link_up = 1;

    // R4 promiscuous
    cfg_promisc = 1;
    send(rnd_addr() & ~48'h1, 64, "R4 promisc unicast");
    send(48'hFFFF_FFFF_FFFF, 64, "R4 promisc broadcast no flag");

    // R7 hash: load three entries
    cfg_promisc = 0;
    for (int e = 0; e < 16; e++) list[e] = rnd_addr() | 48'h1;
    load(3, 18);
    send(list[0], 64, "R7 listed entry 0");
    send(list[2], 64, "R7 listed entry 2");
    send(miss_mcast(), 64, "R7 clear bit");
    cfg_mcast_en = 0;
    send(list[0], 64, "R6 multicast disabled");
    cfg_mcast_en = 1;

    // R9 cap and partial entry
    load(10, 60);
    send(list[7], 64, "R9 last entry under cap");
    send(list[8], 64, "R9 entry past cap");
    send(list[9], 64, "R9 entry past cap");
    for (int e = 0; e < 16; e++) list[e] = rnd_addr() | 48'h1;
    load(3, 17);
    send(list[1], 64, "R9 full entry");
    send(list[2], 64, "R9 partial entry");

    // R8 reload clears
    a = list[0];
    list[0] = list[5];
    load(1, 6);
    send(a, 64, "R8 old entry cleared");
    send(list[0], 64, "R8 new entry");

    // random mix
    for (int e = 0; e < 16; e++) list[e] = rnd_addr() | 48'h1;
    load(6, 36);
    for (int it = 0; it < 400; it++) begin
      int k;
      logic [15:0] ln;
      cfg_promisc   = ($urandom() % 6) == 0;
      cfg_bcast_off = $urandom() % 2;
      cfg_mcast_en  = ($urandom() % 4) != 0;
      cfg_min_len   = 8'($urandom() % 24);
      rx_suspended  = ($urandom() % 10) == 0;
      link_up       = ($urandom() % 10) != 0;
      ln = 16'($urandom() % 40);
      k = $urandom() % 6;
      case (k)
        0: a = 48'hFFFF_FFFF_FFFF;
        1: a = ia_addr;
        2: a = ia_addr ^ (48'h1 << (1 + $urandom() % 47));
        3: a = list[$urandom() % 6];
        4: a = miss_mcast();
        default: a = rnd_addr();
      endcase
      send(a, ln, "R2 R3 R4 R5 R6 R7 R10 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule